// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the host-facing register file of a four-channel DMA controller. A processor programs it over a byte-wide I/O bus: for each channel a 16-bit base address and a 16-bit base count, a mode byte, and a low and a high page byte. At controller level it holds a command byte, a status byte, a channel mask and a byte-order toggle. The 16-bit channel registers are reached one byte at a time through a single port, and one toggle shared by all channels picks the byte. Any read or write of a channel port flips that toggle.

A transfer engine outside this block consumes three things: the service requests (request bits that are not masked), the command byte, and a physical address per channel. It reports each completed transfer cycle back through a step input, which advances that channel's current count. A strap input picks the primary or the secondary instance. The secondary instance sits at a different port base, spaces its ports one word apart, and counts in words, so its current address is the base address doubled.

Top module: `dmac_regfile`

## Requirements
- R1: The primary instance decodes channel and control ports at 0x000–0x00F with offset = address − 0x000. The secondary instance decodes 0xC0–0xDF with offset = (address − 0xC0) >> 1. A read of any address outside every decoded range returns 0xFF, and a write to such an address changes nothing.
- R2: Offsets 0–7 are channel ports. The channel is offset[2:1], and offset[0] selects the address register (0) or the count register (1). A byte toggle, low after reset, picks the low byte (0) or the high byte (1). Every channel-port read or write inverts the toggle, and a write to offset 0xC returns it to low.
- R3: Writing the high byte of either channel register reloads that channel. The current address becomes the new base address shifted left by the instance shift (0 primary, 1 secondary), and the current count becomes 0.
- R4: A count-port read returns the byte of ((base count << shift) − current count) >> shift. An address-port read returns the byte of (current address ± current count) >> shift, where mode bit 5 set means minus.
- R5: A pulse on chan_step[i] adds one to channel i's current count. When the count reaches (base count + 1) << shift, status bit i (terminal count) is set. Once that value is reached, further steps are ignored, unless mode bit 4 (auto-reload) is set, in which case the count returns to 0 on reaching it.
- R6: A write to offset 9 takes the channel from data[1:0] and sets (data[2]=1) or clears (data[2]=0) status bit channel+4. The same write clears status bit channel.
- R7: A write to offset 0xA sets (data[2]=1) or clears mask bit data[1:0]. Offset 0xE clears all mask bits, and offset 0xF loads them from data[3:0]. A read of offset 0xF returns {4'h0, mask}. svc_req equals status[7:4] with masked channels removed.
- R8: A write to offset 0xB stores the mode of the channel given by data[1:0]. Only bit 5 (decrement) and bit 4 (auto-reload) are kept.
- R9: A write to offset 0xD clears the command and the status, sets all mask bits and returns the toggle to low. Channel registers keep their values.
- R10: A write to offset 8 loads ctrl_cmd. A read of offset 8 returns the status byte. A read of offsets 9–0xE returns 0xFF.
- R11: Low page ports sit at 0x80 (primary) or 0x88 (secondary), and high page ports at 0x480 or 0x488. Page offsets 1, 2, 3 and 7 select channels 2, 3, 1 and 0. Other page offsets read 0xFF and ignore writes. A low page holds 8 bits. A high page holds 7 bits and reads back with bit 7 = 0.
- R12: chan_phys[31*i +: 31] equals {high page, low page, current address[15:0]} of channel i.
- R13: After reset the mask is 0xF, the toggle is low, and status, command and all channel registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| secondary | input | 1 | Strap: 0 primary instance, 1 secondary (word-spaced) instance |
| io_addr | input | 12 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data for the current io_addr |
| chan_step | input | 4 | Per-channel transfer-cycle pulse from the engine |
| ctrl_cmd | output | 8 | Command byte |
| svc_req | output | 4 | Unmasked pending requests |
| chan_phys | output | 124 | Per-channel physical address, 31 bits each |

## Verification
The most likely internal fault is a toggle that falls out of step. It shows on the very next channel read, which returns the other byte, and every later pair then stays swapped until a toggle clear or a master clear. A wrong reload or step shows on chan_phys in the cycle after the write, and on the following count or address readback. A status or mask fault shows on svc_req one cycle after the control write. A bad terminal-count compare shows as a missing or early status bit after exactly base+1 steps.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH = 4;
  localparam int CHW = 2;
  localparam int BW  = 8;

  typedef enum logic [3:0] {
    OFS_CMD     = 4'h8,
    OFS_REQ     = 4'h9,
    OFS_MASK1   = 4'hA,
    OFS_MODE    = 4'hB,
    OFS_TGLCLR  = 4'hC,
    OFS_MCLR    = 4'hD,
    OFS_MASKCLR = 4'hE,
    OFS_MASKALL = 4'hF
  } ctl_ofs_e;
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode #(
  parameter int AW           = 12,
  parameter bit HIGH_PAGE_EN = 1'b1
) (
  input  logic [AW-1:0] addr,
  input  logic          secondary,
  output logic          hit_reg,
  output logic [3:0]    reg_ofs,
  output logic          hit_plo,
  output logic          hit_phi,
  output logic          page_ok,
  output logic [1:0]    page_ch
);
  logic [AW-1:0] reg_base, plo_base, rel, prel;

  always_comb begin
    reg_base = secondary ? AW'('h0C0) : AW'('h000);
    plo_base = secondary ? AW'('h088) : AW'('h080);
    rel      = addr - reg_base;
    prel     = addr - plo_base;
    hit_reg  = rel < (secondary ? AW'(32) : AW'(16));
    reg_ofs  = secondary ? rel[4:1] : rel[3:0];
    hit_plo  = prel < AW'(8);
  end

  generate
    if (HIGH_PAGE_EN) begin : g_phi
      logic [AW-1:0] hrel;
      always_comb begin
        hrel    = addr - (secondary ? AW'('h488) : AW'('h480));
        hit_phi = hrel < AW'(8);
      end
    end else begin : g_nophi
      assign hit_phi = 1'b0;
    end
  endgenerate

  // page bases are multiples of 8, so the low address bits are the page offset
  always_comb begin
    page_ok = 1'b1;
    page_ch = 2'd0;
    case (addr[2:0])
      3'd1:    page_ch = 2'd2;
      3'd2:    page_ch = 2'd3;
      3'd3:    page_ch = 2'd1;
      3'd7:    page_ch = 2'd0;
      default: page_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel #(
  parameter int RW    = 16,
  parameter int PLO_W = 8,
  parameter int PHI_W = 7,
  parameter int BW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      secondary,
  input  logic [BW-1:0]             wdata,
  input  logic                      hi_byte,
  input  logic                      wr_addr,
  input  logic                      wr_cnt,
  input  logic                      wr_mode,
  input  logic                      wr_plo,
  input  logic                      wr_phi,
  input  logic                      step,
  output logic [BW-1:0]             addr_byte,
  output logic [BW-1:0]             cnt_byte,
  output logic                      tc_evt,
  output logic [PHI_W+PLO_W+RW-1:0] phys
);
  localparam int XW = RW + 2;

  logic [RW-1:0]    base_addr_q, base_addr_d, base_cnt_q, base_cnt_d;
  logic [RW:0]      cur_addr_q, cur_addr_d;
  logic [XW-1:0]    cur_cnt_q, cur_cnt_d, term_cnt, cnt_inc, addr_val, cnt_val;
  logic             dec_q, dec_d, auto_q, auto_d;
  logic [PLO_W-1:0] plo_q, plo_d;
  logic [PHI_W-1:0] phi_q, phi_d;
  logic             reload, done;
  logic [4:0]       shamt;

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    if (wr_addr) begin
      if (hi_byte) base_addr_d[RW-1:BW] = wdata;
      else         base_addr_d[BW-1:0]  = wdata;
    end
    if (wr_cnt) begin
      if (hi_byte) base_cnt_d[RW-1:BW] = wdata;
      else         base_cnt_d[BW-1:0]  = wdata;
    end
    reload   = hi_byte & (wr_addr | wr_cnt);
    term_cnt = (XW'(base_cnt_q) + XW'(1)) << secondary;
    done     = cur_cnt_q >= term_cnt;
    cnt_inc  = cur_cnt_q + XW'(1);
    tc_evt   = step & ~done & ~reload & (cnt_inc == term_cnt);
    cur_addr_d = cur_addr_q;
    cur_cnt_d  = cur_cnt_q;
    if (reload) begin
      cur_addr_d = secondary ? {base_addr_d, 1'b0} : {1'b0, base_addr_d};
      cur_cnt_d  = '0;
    end else if (step && !done) begin
      cur_cnt_d = (tc_evt && auto_q) ? '0 : cnt_inc;
    end
    dec_d  = wr_mode ? wdata[5] : dec_q;
    auto_d = wr_mode ? wdata[4] : auto_q;
    plo_d  = wr_plo ? wdata[PLO_W-1:0] : plo_q;
    phi_d  = wr_phi ? wdata[PHI_W-1:0] : phi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      dec_q       <= 1'b0;
      auto_q      <= 1'b0;
      plo_q       <= '0;
      phi_q       <= '0;
    end else begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      cur_addr_q  <= cur_addr_d;
      cur_cnt_q   <= cur_cnt_d;
      dec_q       <= dec_d;
      auto_q      <= auto_d;
      plo_q       <= plo_d;
      phi_q       <= phi_d;
    end
  end

  always_comb begin
    addr_val  = dec_q ? (XW'(cur_addr_q) - cur_cnt_q) : (XW'(cur_addr_q) + cur_cnt_q);
    cnt_val   = (XW'(base_cnt_q) << secondary) - cur_cnt_q;
    shamt     = (hi_byte ? 5'(BW) : 5'd0) + {4'd0, secondary};
    addr_byte = BW'(addr_val >> shamt);
    cnt_byte  = BW'(cnt_val >> shamt);
    phys      = {phi_q, plo_q, cur_addr_q[RW-1:0]};
  end

  // after a reload the count readback equals the (scaled) base count
  assert_reload_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !step) |=> (cnt_val == (XW'(base_cnt_q) << secondary)));
  assert_reload_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr && hi_byte && !secondary) |=> (phys[RW-1:0] == base_addr_q));
  assert_autoreload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt && auto_q) |=> (cur_cnt_q == '0));
  assert_step_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && done && !reload) |=> $stable(cur_cnt_q));
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic [3:0]       ofs,
  input  logic [BW-1:0]    wdata,
  input  logic             chan_acc,
  input  logic [NCH-1:0]   tc_evt,
  output logic [BW-1:0]    cmd_q,
  output logic [2*NCH-1:0] status_q,
  output logic [NCH-1:0]   mask_q,
  output logic             tgl_q
);
  logic [BW-1:0]    cmd_d;
  logic [2*NCH-1:0] status_d;
  logic [NCH-1:0]   mask_d;
  logic             tgl_d;
  logic [CHW-1:0]   ch;

  always_comb begin
    ch       = wdata[CHW-1:0];
    cmd_d    = cmd_q;
    mask_d   = mask_q;
    tgl_d    = chan_acc ? ~tgl_q : tgl_q;
    status_d = status_q | {{NCH{1'b0}}, tc_evt};
    if (wr_ctl) begin
      case (ctl_ofs_e'(ofs))
        OFS_CMD: cmd_d = wdata;
        OFS_REQ: begin
          status_d[{1'b1, ch}] = wdata[2];
          status_d[{1'b0, ch}] = 1'b0;
        end
        OFS_MASK1:   mask_d[ch] = wdata[2];
        OFS_TGLCLR:  tgl_d = 1'b0;
        OFS_MCLR: begin
          cmd_d    = '0;
          status_d = '0;
          mask_d   = '1;
          tgl_d    = 1'b0;
        end
        OFS_MASKCLR: mask_d = '0;
        OFS_MASKALL: mask_d = wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      status_q <= '0;
      mask_q   <= '1;
      tgl_q    <= 1'b0;
    end else begin
      cmd_q    <= cmd_d;
      status_q <= status_d;
      mask_q   <= mask_d;
      tgl_q    <= tgl_d;
    end
  end

  assert_toggle_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chan_acc |=> (tgl_q != $past(tgl_q)));
  assert_master_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && ofs == 4'hD) |=> (mask_q == '1 && status_q == '0 && !tgl_q && cmd_q == '0));
  assert_req_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && ofs == 4'h9 && wdata[2]) |=> (status_q[2*NCH-1:NCH] != '0));
  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && ofs == 4'hE) |=> (mask_q == '0));
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_pkg::*;
#(
  parameter int AW           = 12,
  parameter bit HIGH_PAGE_EN = 1'b1,
  parameter int RW           = 16,
  parameter int PLO_W        = 8,
  parameter int PHI_W        = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              secondary,
  input  logic [AW-1:0]                     io_addr,
  input  logic [BW-1:0]                     io_wdata,
  input  logic                              io_wr,
  input  logic                              io_rd,
  output logic [BW-1:0]                     io_rdata,
  input  logic [NCH-1:0]                    chan_step,
  output logic [BW-1:0]                     ctrl_cmd,
  output logic [NCH-1:0]                    svc_req,
  output logic [NCH*(PHI_W+PLO_W+RW)-1:0]   chan_phys
);
  localparam int PW = PHI_W + PLO_W + RW;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic          hit_reg, hit_plo, hit_phi, page_ok;
  logic [3:0]    reg_ofs;
  logic [1:0]    page_ch;
  logic          wr_chan, chan_acc, wr_ctl, tgl;
  logic [2*NCH-1:0] status;
  logic [NCH-1:0]   mask, tc_evt;
  logic [BW-1:0]    addr_b [NCH];
  logic [BW-1:0]    cnt_b  [NCH];
  logic [PW-1:0]    phys_w [NCH];

  dmac_decode #(.AW(AW), .HIGH_PAGE_EN(HIGH_PAGE_EN)) i_decode (
    .addr(io_addr), .secondary(secondary), .hit_reg(hit_reg), .reg_ofs(reg_ofs),
    .hit_plo(hit_plo), .hit_phi(hit_phi), .page_ok(page_ok), .page_ch(page_ch)
  );

  assign wr_chan  = io_wr & hit_reg & ~reg_ofs[3];
  assign chan_acc = (io_wr | io_rd) & hit_reg & ~reg_ofs[3];
  assign wr_ctl   = io_wr & hit_reg & reg_ofs[3];

  dmac_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_ni), .wr_ctl(wr_ctl), .ofs(reg_ofs), .wdata(io_wdata),
    .chan_acc(chan_acc), .tc_evt(tc_evt), .cmd_q(ctrl_cmd), .status_q(status),
    .mask_q(mask), .tgl_q(tgl)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel_reg, sel_page;
      assign sel_reg  = wr_chan & (reg_ofs[2:1] == CHW'(i));
      assign sel_page = page_ok & (page_ch == CHW'(i));
      dmac_channel #(.RW(RW), .PLO_W(PLO_W), .PHI_W(PHI_W), .BW(BW)) i_chan (
        .clk(clk), .rst_n(rst_ni), .secondary(secondary), .wdata(io_wdata),
        .hi_byte(tgl),
        .wr_addr(sel_reg & ~reg_ofs[0]),
        .wr_cnt(sel_reg & reg_ofs[0]),
        .wr_mode(wr_ctl & (reg_ofs == 4'hB) & (io_wdata[CHW-1:0] == CHW'(i))),
        .wr_plo(io_wr & hit_plo & sel_page),
        .wr_phi(io_wr & hit_phi & sel_page),
        .step(chan_step[i]),
        .addr_byte(addr_b[i]), .cnt_byte(cnt_b[i]), .tc_evt(tc_evt[i]),
        .phys(phys_w[i])
      );
      assign chan_phys[i*PW +: PW] = phys_w[i];
    end
  endgenerate

  assign svc_req = status[2*NCH-1:NCH] & ~mask;

  always_comb begin
    io_rdata = '1;
    if (hit_reg) begin
      if (!reg_ofs[3])         io_rdata = reg_ofs[0] ? cnt_b[reg_ofs[2:1]] : addr_b[reg_ofs[2:1]];
      else if (reg_ofs == 4'h8) io_rdata = status;
      else if (reg_ofs == 4'hF) io_rdata = BW'(mask);
    end else if (hit_plo) begin
      if (page_ok) io_rdata = phys_w[page_ch][PW-PHI_W-1:RW];
    end else if (hit_phi) begin
      if (page_ok) io_rdata = BW'(phys_w[page_ch][PW-1:PW-PHI_W]);
    end
  end

  assert_phi_width_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit_phi && page_ok && !hit_reg && !hit_plo) |-> !io_rdata[BW-1]);
  assert_svc_masked_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (io_wr && hit_reg && reg_ofs == 4'hD) |=> (svc_req == '0));
endmodule

// File: tb/test_dmac_regfile.sv
module test_dmac_regfile;
  logic         clk = 1'b0;
  logic         rst_n, secondary, io_wr, io_rd;
  logic [11:0]  io_addr;
  logic [7:0]   io_wdata, io_rdata, ctrl_cmd;
  logic [3:0]   chan_step, svc_req;
  logic [123:0] chan_phys;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dmac_regfile i_dmac_regfile (
    .clk(clk), .rst_n(rst_n), .secondary(secondary), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .chan_step(chan_step), .ctrl_cmd(ctrl_cmd), .svc_req(svc_req), .chan_phys(chan_phys)
  );

  typedef struct packed {
    logic       wr;
    logic [11:0] adr;
    logic [7:0] dat;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h00C, 8'h00, 4'd2},  // R2 toggle clear
    '{1'b1, 12'h002, 8'h34, 4'd2},  // R2 ch1 address low
    '{1'b1, 12'h002, 8'h12, 4'd3},  // R3 high byte reloads
    '{1'b1, 12'h003, 8'h05, 4'd2},
    '{1'b1, 12'h003, 8'h00, 4'd3},
    '{1'b0, 12'h002, 8'h34, 4'd4},  // R4 address readback
    '{1'b0, 12'h002, 8'h12, 4'd4},
    '{1'b0, 12'h003, 8'h05, 4'd4},  // R4 count readback
    '{1'b0, 12'h003, 8'h00, 4'd4},
    '{1'b1, 12'h083, 8'hAB, 4'd11}, // R11 ch1 low page
    '{1'b1, 12'h483, 8'hFF, 4'd11},
    '{1'b0, 12'h083, 8'hAB, 4'd11},
    '{1'b0, 12'h483, 8'h7F, 4'd11}, // R11 7-bit high page
    '{1'b1, 12'h084, 8'h55, 4'd11},
    '{1'b0, 12'h084, 8'hFF, 4'd11},
    '{1'b0, 12'h087, 8'h00, 4'd11},
    '{1'b1, 12'h00F, 8'h00, 4'd7},  // R7 mask all
    '{1'b0, 12'h00F, 8'h00, 4'd7},
    '{1'b1, 12'h00A, 8'h05, 4'd7},
    '{1'b0, 12'h00F, 8'h02, 4'd7},
    '{1'b1, 12'h00F, 8'h0B, 4'd7},
    '{1'b0, 12'h00F, 8'h0B, 4'd7},
    '{1'b1, 12'h00A, 8'h01, 4'd7},
    '{1'b0, 12'h00F, 8'h09, 4'd7},
    '{1'b1, 12'h00E, 8'h00, 4'd7},
    '{1'b0, 12'h00F, 8'h00, 4'd7},
    '{1'b1, 12'h009, 8'h06, 4'd6},  // R6 request ch2
    '{1'b0, 12'h008, 8'h40, 4'd10}, // R10 status read
    '{1'b1, 12'h009, 8'h02, 4'd6},
    '{1'b0, 12'h008, 8'h00, 4'd10},
    '{1'b0, 12'h00A, 8'hFF, 4'd10},
    '{1'b0, 12'h010, 8'hFF, 4'd1},  // R1 outside decode
    '{1'b1, 12'h008, 8'h5A, 4'd10},
    '{1'b0, 12'h00D, 8'hFF, 4'd10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 chk(req, {24'h0, io_rdata}, {24'h0, e});
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic stepn(input logic [3:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); chan_step = m;
      @(negedge clk); chan_step = 4'h0;
    end
  endtask

  task automatic do_reset(input logic sec);
    rst_n = 1'b0; secondary = sec;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    io_addr = '0; io_wdata = '0; io_wr = 0; io_rd = 0; chan_step = '0;
    do_reset(1'b0);
    // R13 reset state
    chk("R13 svc", {28'h0, svc_req}, 32'h0);
    chk("R13 cmd", {24'h0, ctrl_cmd}, 32'h0);
    chk("R13 phys", chan_phys[31:0], 32'h0);
    rd(12'h00F, 8'h0F, "R13 mask");
    rd(12'h008, 8'h00, "R13 status");
    rd(12'h000, 8'h00, "R13 ch0 lo");
    rd(12'h000, 8'h00, "R13 ch0 hi");

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].wr) wr(VEC[v].adr, VEC[v].dat);
      else rd(VEC[v].adr, VEC[v].dat, $sformatf("R%0d vec%0d", VEC[v].req, v));
    end

    chk("R10 cmd", {24'h0, ctrl_cmd}, 32'h5A);
    chk("R12 phys ch1", {1'b0, chan_phys[61:31]}, {1'b0, 7'h7F, 8'hAB, 16'h1234});

    // R7 service request gating
    wr(12'h009, 8'h06);
    chk("R7 svc", {28'h0, svc_req}, 32'h4);
    wr(12'h00A, 8'h06);
    chk("R7 svc masked", {28'h0, svc_req}, 32'h0);
    wr(12'h00A, 8'h02);
    chk("R7 svc unmasked", {28'h0, svc_req}, 32'h4);
    wr(12'h009, 8'h02);

    // R5 stepping, R4 and R8 direction
    wr(12'h00B, 8'h01);
    stepn(4'b0010, 3);
    rd(12'h002, 8'h37, "R4 inc lo");
    rd(12'h002, 8'h12, "R4 inc hi");
    rd(12'h003, 8'h02, "R4 cnt lo");
    rd(12'h003, 8'h00, "R4 cnt hi");
    wr(12'h00B, 8'h21);
    rd(12'h002, 8'h31, "R8 dec lo");
    rd(12'h002, 8'h12, "R8 dec hi");
    stepn(4'b0010, 3);
    rd(12'h008, 8'h02, "R5 tc set");
    stepn(4'b0010, 1);
    rd(12'h003, 8'hFF, "R5 step ignored lo");
    rd(12'h003, 8'hFF, "R5 step ignored hi");
    wr(12'h009, 8'h01);
    rd(12'h008, 8'h00, "R6 tc cleared");

    // R5 auto-reload
    wr(12'h00B, 8'h11);
    wr(12'h003, 8'h05);
    wr(12'h003, 8'h00);
    stepn(4'b0010, 6);
    rd(12'h008, 8'h02, "R5 auto tc");
    rd(12'h003, 8'h05, "R5 auto count lo");
    rd(12'h003, 8'h00, "R5 auto count hi");

    // R9 master clear
    rd(12'h002, 8'h34, "R4 lo before clear");
    wr(12'h00F, 8'h00);
    wr(12'h009, 8'h04);
    chk("R7 svc ch0", {28'h0, svc_req}, 32'h1);
    wr(12'h00D, 8'h00);
    chk("R9 svc", {28'h0, svc_req}, 32'h0);
    chk("R9 cmd", {24'h0, ctrl_cmd}, 32'h0);
    rd(12'h00F, 8'h0F, "R9 mask");
    rd(12'h008, 8'h00, "R9 status");
    rd(12'h002, 8'h34, "R9 toggle low, regs kept");

    // secondary instance
    do_reset(1'b1);
    wr(12'h0C0, 8'h00);
    wr(12'h0C0, 8'h10);
    chk("R3 sec phys", {1'b0, chan_phys[30:0]}, 32'h0000_2000);
    rd(12'h0C0, 8'h00, "R4 sec addr lo");
    rd(12'h0C0, 8'h10, "R4 sec addr hi");
    wr(12'h0C2, 8'h03);
    wr(12'h0C2, 8'h00);
    stepn(4'b0001, 2);
    rd(12'h0C2, 8'h02, "R4 sec cnt lo");
    rd(12'h0C2, 8'h00, "R4 sec cnt hi");
    wr(12'h08F, 8'h12);
    chk("R12 sec phys", {1'b0, chan_phys[30:0]}, {1'b0, 7'h00, 8'h12, 16'h2000});
    rd(12'h08F, 8'h12, "R11 sec page");
    rd(12'h0DE, 8'h0F, "R1 sec mask");
    rd(12'h00F, 8'hFF, "R1 primary port unused");
    stepn(4'b0001, 5);
    rd(12'h0D0, 8'h00, "R5 sec before tc");
    stepn(4'b0001, 1);
    rd(12'h0D0, 8'h01, "R5 sec tc");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule